// File: doc/BRIEF.md
# Round-Robin Conversion Sequencer

This block decides when an external successive-approximation converter core begins each conversion and which analog input it samples. Software-level control arrives as plain signals: an enable, a one-shot start request, a continuous-run level, a channel write port and a per-channel scan mask. The block turns these into a single-cycle launch pulse with a channel index. It then waits for the core's completion strobe, which carries a result word and an error bit.

In continuous mode, conversions either follow one another without a gap or wait for ticks from an external rate divider. When the scan mask is non-zero, the channel register is rewritten after every completed conversion with the next channel the mask enables. The scan therefore starts from whatever channel the register holds when the run begins. Status outputs give readiness, the error bit of the latest conversion, an error flag that stays set until cleared, and the latest result.

Top module: `adc_rr_sequencer`

## Requirements
- R1: After reset, `conv_start`, `ready`, `err_last` and `err_sticky` are 0, `chan_sel` is 0 and `result` is 0.
- R2: With `en`=1, `start_many`=0 and the block idle, a one-cycle `start_once` pulse produces exactly one `conv_start` pulse, one cycle long, in the cycle after the request. `conv_chan` then equals `chan_sel`. A request made while busy is held and launched once the block is idle.
- R3: A `start_once` pulse while `start_many`=1 has no effect, and it does not launch a conversion after `start_many` is released.
- R4: With `start_many`=1 and `pace_on`=0, the next `conv_start` comes in the second cycle after the cycle in which `conv_done` is high. With a core latency of L cycles, launches are therefore L+1 cycles apart.
- R5: With `start_many`=1 and `pace_on`=1, a conversion is launched only after a `pace_tick`. A tick in an idle cycle gives `conv_start` in the next cycle.
- R6: `ready` is 0 from the `conv_start` cycle until the completion strobe has been taken. While enabled and idle, `ready` is 1 exactly when no launch is requested in that cycle.
- R7: While `en`=0, no conversion starts and `ready` is 0. A held one-shot request is discarded and does not launch when `en` returns to 1.
- R8: When `rr_mask` (bit i enables channel i, 5 channels) is non-zero, `chan_sel` becomes the lowest enabled channel above the current one after each completed conversion, wrapping to channel 0. The first launch uses the current `chan_sel` even if its bit is clear. With a zero mask, `chan_sel` does not change.
- R9: At each completed conversion, `result` takes `conv_result` and `err_last` takes `conv_err`.
- R10: `err_sticky` sets on any completed conversion with `conv_err`=1 and clears on an `err_clr` pulse. If both occur in the same cycle, the set wins.
- R11: A `chan_wr` with a value of 5 or more leaves `chan_sel` unchanged. A valid write that falls in the same cycle as a scan advance wins over the advance.
- R12: A `conv_done` strobe while no conversion is in progress changes neither `result`, `err_last` nor `err_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| start_once | input | 1 | One-cycle single-conversion request |
| start_many | input | 1 | Continuous-run level |
| pace_on | input | 1 | Rate divider programmed non-zero |
| pace_tick | input | 1 | Rate divider tick |
| chan_wr | input | 1 | Channel register write strobe |
| chan_wdata | input | 3 | Channel write value |
| rr_mask | input | 5 | Scan mask, one bit per channel |
| err_clr | input | 1 | Clear pulse for the sticky error |
| conv_done | input | 1 | Core completion strobe |
| conv_result | input | 12 | Core result word |
| conv_err | input | 1 | Core error bit |
| conv_start | output | 1 | Launch pulse to the core |
| conv_chan | output | 3 | Channel of the launched conversion |
| chan_sel | output | 3 | Current channel register |
| ready | output | 1 | Idle and able to accept a start |
| result | output | 12 | Latest result |
| err_last | output | 1 | Error bit of the latest conversion |
| err_sticky | output | 1 | Error seen since last clear |

## Verification
The launch logic is driven in four patterns: isolated one-shot pulses, gap-free continuous runs, runs paced by ticks, and one-shot pulses mixed into continuous runs. These show apart a start that is queued, one that is dropped, and one that is timed by a tick. Scan masks cover sparse patterns, a single bit, a full mask and zero, with starting channels both inside and outside the mask. These show wrap-around, a start from an unmasked channel, and a frozen channel register. Directed same-cycle collisions cover a clear against an error and a write against a scan advance. Seeded random runs vary latency, mask, start channel and error rate against a bench reference of the channel sequence.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BUSY = 1'b1
   } seq_state_e;
endpackage

// File: rtl/adcseq_rr_pick.sv
module adcseq_rr_pick #(
   parameter int NUM_CH = 5,
   parameter int CH_W   = 3
) (
   input  logic [CH_W-1:0]   cur,
   input  logic [NUM_CH-1:0] mask,
   output logic [CH_W-1:0]   nxt
);
   logic [CH_W-1:0]   cand [NUM_CH];
   logic [NUM_CH-1:0] hit;

   // candidate k is the channel at distance k+1 above cur, modulo NUM_CH
   for (genvar k = 0; k < NUM_CH; k++) begin : g_off
      assign cand[k] = CH_W'((32'(cur) + k + 1) % NUM_CH);
      assign hit[k]  = |(mask & (NUM_CH'(1) << cand[k]));
   end

   // smallest distance wins
   always_comb begin
      nxt = cur;
      for (int k = NUM_CH - 1; k >= 0; k--) begin
         if (hit[k]) nxt = cand[k];
      end
   end
endmodule

// File: rtl/adcseq_launch_ctrl.sv
module adcseq_launch_ctrl
   import adcseq_pkg::*;
#(
   parameter int CH_W       = 3,
   parameter bit PACE_QUEUE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            start_once,
   input  logic            start_many,
   input  logic            pace_on,
   input  logic            pace_tick,
   input  logic [CH_W-1:0] chan_sel,
   input  logic            conv_done,
   output logic            conv_start,
   output logic [CH_W-1:0] conv_chan,
   output logic            ready,
   output logic            done_acc
);
   seq_state_e state_q;
   logic       once_pend_q;
   logic       tick_pend_q;
   logic       once_req, many_req, go;

   assign once_req = en && !start_many && (start_once || once_pend_q);
   assign many_req = en && start_many && (!pace_on || pace_tick || tick_pend_q);
   assign go       = (state_q == SEQ_IDLE) && (once_req || many_req);
   assign done_acc = (state_q == SEQ_BUSY) && conv_done;
   assign ready    = en && (state_q == SEQ_IDLE) && !go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
      end else if (go) begin
         state_q <= SEQ_BUSY;
      end else if (done_acc) begin
         state_q <= SEQ_IDLE;
      end
   end

   // one-shot request held while a conversion is running
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         once_pend_q <= 1'b0;
      end else if (!en || start_many || go) begin
         once_pend_q <= 1'b0;
      end else if (start_once) begin
         once_pend_q <= 1'b1;
      end
   end

   // tick memory: variant chosen by parameter
   if (PACE_QUEUE) begin : g_tick_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tick_pend_q <= 1'b0;
         end else if (!en || !start_many || !pace_on || go) begin
            tick_pend_q <= 1'b0;
         end else if (pace_tick) begin
            tick_pend_q <= 1'b1;
         end
      end
   end else begin : g_tick_drop
      assign tick_pend_q = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_start <= 1'b0;
         conv_chan  <= '0;
      end else begin
         conv_start <= go;
         if (go) conv_chan <= chan_sel;
      end
   end

   // R2
   start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   // R7
   start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> $past(en));
   // R6
   ready_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !ready);
   // R3
   once_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_many && pace_on && !pace_tick && !tick_pend_q) |=> !conv_start);
endmodule

// File: rtl/adcseq_chan_reg.sv
module adcseq_chan_reg #(
   parameter int NUM_CH = 5,
   parameter int CH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_wr,
   input  logic [CH_W-1:0]   chan_wdata,
   input  logic              done_acc,
   input  logic [NUM_CH-1:0] rr_mask,
   input  logic [CH_W-1:0]   rr_next,
   output logic [CH_W-1:0]   chan_sel
);
   logic wr_ok;
   logic scan_on;

   assign wr_ok   = chan_wr && ({1'b0, chan_wdata} < (CH_W+1)'(NUM_CH));
   assign scan_on = |rr_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_sel <= '0;
      end else if (wr_ok) begin
         chan_sel <= chan_wdata;
      end else if (done_acc && scan_on) begin
         chan_sel <= rr_next;
      end
   end

   // R11
   bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_wr && !wr_ok && !(done_acc && scan_on)) |=> $stable(chan_sel));
   // R8
   rr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_acc && scan_on && !chan_wr) |=> (chan_sel == $past(rr_next)));
   // R8
   rr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_on && !chan_wr) |=> $stable(chan_sel));
endmodule

// File: rtl/adcseq_status.sv
module adcseq_status #(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_acc,
   input  logic [RES_W-1:0] conv_result,
   input  logic             conv_err,
   input  logic             err_clr,
   output logic [RES_W-1:0] result,
   output logic             err_last,
   output logic             err_sticky
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result   <= '0;
         err_last <= 1'b0;
      end else if (done_acc) begin
         result   <= conv_result;
         err_last <= conv_err;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_sticky <= 1'b0;
      end else if (done_acc && conv_err) begin
         err_sticky <= 1'b1;
      end else if (err_clr) begin
         err_sticky <= 1'b0;
      end
   end

   // R10
   sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_acc && conv_err) |=> err_sticky);
   // R12
   idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_acc |=> ($stable(result) && $stable(err_last)));
endmodule

// File: rtl/adc_rr_sequencer.sv
module adc_rr_sequencer #(
   parameter int NUM_CH     = 5,
   parameter int CH_W       = $clog2(NUM_CH),
   parameter int RES_W      = 12,
   parameter bit PACE_QUEUE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              start_once,
   input  logic              start_many,
   input  logic              pace_on,
   input  logic              pace_tick,
   input  logic              chan_wr,
   input  logic [CH_W-1:0]   chan_wdata,
   input  logic [NUM_CH-1:0] rr_mask,
   input  logic              err_clr,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   input  logic              conv_err,
   output logic              conv_start,
   output logic [CH_W-1:0]   conv_chan,
   output logic [CH_W-1:0]   chan_sel,
   output logic              ready,
   output logic [RES_W-1:0]  result,
   output logic              err_last,
   output logic              err_sticky
);
   if (NUM_CH < 2 || (1 << CH_W) < NUM_CH || RES_W < 1) begin : g_bad_cfg
      $error("adc_rr_sequencer: inconsistent channel or result width");
   end

   logic            done_acc;
   logic [CH_W-1:0] rr_next;

   adcseq_launch_ctrl #(.CH_W(CH_W), .PACE_QUEUE(PACE_QUEUE)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .start_once (start_once),
      .start_many (start_many),
      .pace_on    (pace_on),
      .pace_tick  (pace_tick),
      .chan_sel   (chan_sel),
      .conv_done  (conv_done),
      .conv_start (conv_start),
      .conv_chan  (conv_chan),
      .ready      (ready),
      .done_acc   (done_acc)
   );

   adcseq_rr_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
      .cur  (chan_sel),
      .mask (rr_mask),
      .nxt  (rr_next)
   );

   adcseq_chan_reg #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_wr    (chan_wr),
      .chan_wdata (chan_wdata),
      .done_acc   (done_acc),
      .rr_mask    (rr_mask),
      .rr_next    (rr_next),
      .chan_sel   (chan_sel)
   );

   adcseq_status #(.RES_W(RES_W)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_acc    (done_acc),
      .conv_result (conv_result),
      .conv_err    (conv_err),
      .err_clr     (err_clr),
      .result      (result),
      .err_last    (err_last),
      .err_sticky  (err_sticky)
   );

   // R7
   disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !ready);
   // R12
   stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && ready) |=> ($stable(result) && $stable(err_last)));
endmodule

// File: tb/test_adc_rr_sequencer.sv
`timescale 1ns/1ps
module test_adc_rr_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 0, start_once = 0, start_many = 0, pace_on = 0, pace_tick = 0;
   logic        chan_wr = 0, err_clr = 0;
   logic [2:0]  chan_wdata = '0;
   logic [4:0]  rr_mask = '0;
   logic        done_m = 0, done_x = 0, err_m = 0, err_x = 0;
   logic [11:0] res_m = '0, res_x = '0;
   logic        conv_start, ready, err_last, err_sticky;
   logic [2:0]  conv_chan, chan_sel;
   logic [11:0] result;

   int checks = 0, errors = 0;
   int n_starts = 0, n_done = 0, cyc_n = 0, prev_t = 0, last_t = 0;
   int lat_cfg = 2, err_cfg = 0, n_log = 0;
   bit model_off = 0;
   int exp_chan = 0;
   int log_ch [8];

   always #2 clk = ~clk;
   always @(posedge clk) cyc_n++;

   adc_rr_sequencer i_adc_rr_sequencer (
      .clk(clk), .rst_n(rst_n), .en(en), .start_once(start_once),
      .start_many(start_many), .pace_on(pace_on), .pace_tick(pace_tick),
      .chan_wr(chan_wr), .chan_wdata(chan_wdata), .rr_mask(rr_mask),
      .err_clr(err_clr), .conv_done(done_m | done_x),
      .conv_result(done_m ? res_m : res_x), .conv_err(done_m ? err_m : err_x),
      .conv_start(conv_start), .conv_chan(conv_chan), .chan_sel(chan_sel),
      .ready(ready), .result(result), .err_last(err_last), .err_sticky(err_sticky));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int nxt_ch(input int c, input logic [4:0] m);
      for (int k = 1; k <= 5; k++) begin
         if (m[(c + k) % 5]) return (c + k) % 5;
      end
      return c;
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_quiet();
      int q = 0;
      start_many = 0;
      while (q < 3) begin
         cyc(1);
         if (n_done == n_starts && !conv_start) q++; else q = 0;
      end
   endtask

   task automatic pulse_once();
      start_once = 1; cyc(1); start_once = 0;
   endtask

   task automatic write_chan(input int v);
      chan_wr = 1; chan_wdata = 3'(v); cyc(1); chan_wr = 0;
   endtask

   // converter core model and per-conversion reference checks
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && conv_start) begin
            n_starts++;
            prev_t = last_t; last_t = cyc_n;
            chk(32'(conv_chan) == exp_chan, "R8 launch channel", conv_chan, exp_chan);
            if (n_log < 8) begin log_ch[n_log] = conv_chan; n_log++; end
            if (!model_off) begin
               int lat;
               lat = (lat_cfg == 0) ? $urandom_range(1, 6) : lat_cfg;
               repeat (lat - 1) @(negedge clk);
               res_m = 12'($urandom);
               err_m = (err_cfg == 0) ? ($urandom_range(0, 3) == 0) : (err_cfg == 2);
               done_m = 1;
               @(negedge clk);
               done_m = 0;
               n_done++;
               chk(result == res_m, "R9 result", result, res_m);
               chk(err_last == err_m, "R9 last error", err_last, err_m);
               if (err_m) chk(err_sticky, "R10 sticky set", err_sticky, 1);
               if (rr_mask != 0) exp_chan = nxt_ch(exp_chan, rr_mask);
               chk(32'(chan_sel) == exp_chan, "R8 channel advance", chan_sel, exp_chan);
            end
         end
      end
   end

   initial begin
      #600000;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_n, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int base, r0, e0;
      void'($urandom(32'h5eed1234));
      cyc(5);
      rst_n = 1;
      cyc(1);
      // R1 reset state
      chk(!conv_start && !ready, "R1 start/ready", {conv_start, ready}, 0);
      chk(!err_last && !err_sticky, "R1 error flags", {err_last, err_sticky}, 0);
      chk(chan_sel == 0 && result == 0, "R1 channel/result", chan_sel, 0);

      // R7 disabled: start ignored
      pulse_once(); cyc(5);
      chk(n_starts == 0, "R7 no start when disabled", n_starts, 0);

      // R2 / R6 single start
      en = 1; cyc(1);
      chk(ready, "R6 ready when idle", ready, 1);
      lat_cfg = 3; err_cfg = 1;
      start_once = 1; cyc(1); start_once = 0;
      chk(conv_start == 1, "R2 launch next cycle", conv_start, 1);
      chk(ready == 0, "R6 ready low while busy", ready, 0);
      wait_quiet(); cyc(5);
      chk(n_starts == 1, "R2 exactly one launch", n_starts, 1);

      // R2 request while busy is held
      lat_cfg = 6;
      pulse_once(); cyc(1); pulse_once();
      wait_quiet();
      chk(n_starts == 3, "R2 queued request launches", n_starts, 3);

      // R3 / R5 paced continuous
      lat_cfg = 2; pace_on = 1; start_many = 1; cyc(3);
      base = n_starts;
      pulse_once(); cyc(10);
      chk(n_starts == base, "R3 once ignored in continuous", n_starts, base);
      chk(n_starts == base, "R5 no launch without tick", n_starts, base);
      pace_tick = 1; cyc(1); pace_tick = 0;
      chk(conv_start == 1, "R5 tick launches next cycle", conv_start, 1);
      wait_quiet(); cyc(4);
      chk(n_starts == base + 1, "R3 no late launch", n_starts, base + 1);

      // R4 back-to-back with latency 3
      pace_on = 0; lat_cfg = 3; base = n_starts; start_many = 1;
      while (n_starts < base + 2) cyc(1);
      chk(ready == 0, "R6 ready low in continuous run", ready, 0);
      while (n_starts < base + 4) cyc(1);
      chk(last_t - prev_t == 4, "R4 launch spacing", last_t - prev_t, 4);
      wait_quiet();

      // R7 held request dropped by disable
      lat_cfg = 8; base = n_starts;
      pulse_once(); cyc(1); pulse_once();
      en = 0; cyc(1);
      chk(ready == 0, "R7 ready low when disabled", ready, 0);
      wait_quiet(); en = 1; cyc(10);
      chk(n_starts == base + 1, "R7 held request discarded", n_starts, base + 1);

      // R8 scan from unmasked channel 3 with mask 10101
      lat_cfg = 2; write_chan(3); exp_chan = 3;
      rr_mask = 5'b10101; n_log = 0; base = n_starts; start_many = 1;
      while (n_starts < base + 5) cyc(1);
      wait_quiet();
      chk(log_ch[0] == 3 && log_ch[1] == 4 && log_ch[2] == 0, "R8 sequence head",
          log_ch[1] * 10 + log_ch[2], 40);
      chk(log_ch[3] == 2 && log_ch[4] == 4, "R8 sequence wrap", log_ch[3] * 10 + log_ch[4], 24);
      // R8 zero mask keeps channel
      rr_mask = 0; r0 = chan_sel; pulse_once(); wait_quiet();
      chk(32'(chan_sel) == r0, "R8 zero mask keeps channel", chan_sel, r0);

      // manual core from here
      model_off = 1; wait_quiet();
      err_clr = 1; cyc(1); err_clr = 0;
      chk(err_sticky == 0, "R10 clear", err_sticky, 0);

      // R12 stray done
      r0 = result; e0 = err_last;
      done_x = 1; res_x = 12'hABC; err_x = 1; cyc(1); done_x = 0;
      chk(32'(result) == r0 && err_last == e0, "R12 stray done ignored", result, r0);
      chk(err_sticky == 0, "R12 sticky untouched", err_sticky, 0);

      // R10 set wins over clear
      pulse_once();
      done_x = 1; err_x = 1; res_x = 12'h123; err_clr = 1; cyc(1);
      done_x = 0; err_clr = 0; n_done++;
      chk(err_sticky == 1, "R10 set wins", err_sticky, 1);
      chk(result == 12'h123 && err_last, "R9 manual result", result, 12'h123);
      err_clr = 1; cyc(1); err_clr = 0;
      chk(err_sticky == 0 && err_last == 1, "R10 clear keeps last", {err_sticky, err_last}, 1);

      // R11 write beats scan advance, bad writes ignored
      rr_mask = 5'b00011; write_chan(0); exp_chan = 0;
      pulse_once();
      done_x = 1; err_x = 0; chan_wr = 1; chan_wdata = 3'd4; cyc(1);
      done_x = 0; chan_wr = 0; n_done++; exp_chan = 4;
      chk(chan_sel == 4, "R11 write wins", chan_sel, 4);
      write_chan(6); cyc(1);
      chk(chan_sel == 4, "R11 value 6 ignored", chan_sel, 4);
      write_chan(5); cyc(1);
      chk(chan_sel == 4, "R11 value 5 ignored", chan_sel, 4);
      model_off = 0; rr_mask = 0;

      // random episodes
      for (int ep = 0; ep < 40; ep++) begin
         int ch;
         ch = $urandom_range(0, 4);
         rr_mask = 5'($urandom_range(0, 31));
         write_chan(ch); exp_chan = ch;
         lat_cfg = 0; err_cfg = 0;
         if ($urandom_range(0, 3) == 0) begin
            for (int i = 0; i < 3; i++) begin pulse_once(); wait_quiet(); end
         end else begin
            pace_on = 1'($urandom_range(0, 1));
            start_many = 1;
            for (int i = 0; i < 80; i++) begin
               pace_tick = pace_on && ($urandom_range(0, 7) == 0);
               start_once = ($urandom_range(0, 15) == 0);
               cyc(1);
            end
            pace_tick = 0; start_once = 0;
            wait_quiet();
         end
         if (err_sticky) begin err_clr = 1; cyc(1); err_clr = 0; end
         chk(ready == 1, "R6 ready after episode", ready, 1);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule